// File: doc/BRIEF.md
# Accumulator Processor Sequencer

This block is the control unit of a 16-bit single-accumulator processor with four instructions: load, store, add and branch-when-negative. It is written as a synchronous Mealy machine. Every datapath enable and memory strobe belongs to a transition and is a function of the present state and the synchronized inputs. The datapath registers react on the clock edge that ends the cycle, which is the edge that enters the next state. The registers are the program counter, the memory address and buffer registers, the instruction register and the accumulator. The block holds none of them. It only tells them when to move. A wider system wires its enables to the registers, the ALU and the three internal buses: the address bus, the memory-side bus and the result bus.

Memory is reached through a four-phase handshake. The memory holds `mem_wait` high while it is idle. The controller raises `mem_req` and holds it until memory drops `mem_wait` to say that the access is done. The controller then lowers `mem_req`, and memory raises `mem_wait` again. The external reset and `mem_wait` each pass through a two-flop synchronizer before the state logic sees them.

The states are RES, IF0, IF1, IF2, OD, LD0/LD1/LD2, AD0/AD1/AD2, ST0/ST1 and BR0. The transitions are as follows:
- RES goes to IF0.
- IF0 loops until Wait is high, then goes to IF1.
- IF1 loops while Wait is high, then goes to IF2.
- IF2 loops until Wait is high, then goes to OD.
- OD goes to LD0, ST0, AD0 or BR0, chosen by the opcode.
- LD0 goes to LD1. LD1 loops while Wait is high, then goes to LD2. LD2 goes to IF0. The AD states follow the same pattern.
- ST0 goes to ST1. ST1 loops while Wait is high, then goes to IF0.
- BR0 goes to IF0.
- Synchronized reset sends any state to RES.

Top module: `acc_seq_ctrl`

## Requirements
- R1: The external reset and Wait each reach the state logic through two flops. While the synchronized reset is high, the next state is RES, `pc_clr` is 1 and `mem_req` is 0. As a result, `pc_clr` rises on the second rising edge after `ext_reset` rises.
- R2: Every transition into IF0 asserts `pc_to_abus`, `abus_to_mar` and `pc_inc` together. The transitions into IF0 come from RES, LD2, AD2, ST1 and BR0. MAR therefore takes the old PC, and PC becomes PC+1. At most one source drives the address bus in any cycle.
- R3: IF0 holds with `mem_req` low while the synchronized Wait is low. The transition out of IF0 asserts `mar_to_maddr`, `mem_rd_nwr`=1 and `mem_req`. `mem_req` rises on the second edge after `mem_wait` rises.
- R4: In IF1, LD1 and AD1, `mem_req` stays high while the synchronized Wait is high. When Wait falls, the transition asserts `mdata_to_mbr` and lowers `mem_req`. `mem_req` never falls while the synchronized Wait is high.
- R5: IF2 holds until the synchronized Wait is high. Its exit asserts `mbr_to_mbus` and `mbus_to_ir`, and the next state is OD.
- R6: OD decodes `ir_opcode`, which is IR bits 15:14. The value 00 selects load, 01 selects store, 10 selects add and 11 selects branch-when-negative. For load, store and add, the OD transition asserts `ir_to_abus` and `abus_to_mar`, so MAR takes IR bits 13:0.
- R7: Load and add each run one read handshake. The last transition asserts `mbr_to_mbus`, `mbus_to_alub` and `rbus_to_ac`, together with `alu_pass_b` for load or `alu_add` for add. The result is AC = M[a] for load and AC = (AC + M[a]) mod 2^16 for add.
- R8: Store copies AC into MBR on the OD transition. It does this with `rbus_to_mbr` while neither `alu_add` nor `alu_pass_b` is set, which means the ALU passes A. It then drives `mar_to_maddr`, `mbr_to_mdata`, `mem_rd_nwr`=0 and `mem_req` until the synchronized Wait falls, and then returns to the fetch.
- R9: On the OD transition for branch, `ir_to_abus` and `abus_to_pc` are asserted only if `acc_sign` is 1. Otherwise PC keeps its incremented value. BR0 then starts the next fetch.
- R10: Taken as a whole, a request begins only while memory shows Wait high and ends only after memory shows Wait low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_reset | input | 1 | Asynchronous external reset, active high; synchronized inside |
| mem_wait | input | 1 | Memory Wait: high when idle or ready, low when the access is done |
| ir_opcode | input | 2 | IR bits 15:14 |
| acc_sign | input | 1 | AC bit 15 |
| pc_clr | output | 1 | Clear the PC |
| pc_inc | output | 1 | Increment the PC |
| pc_to_abus | output | 1 | PC drives the address bus |
| ir_to_abus | output | 1 | IR bits 13:0 drive the address bus |
| abus_to_mar | output | 1 | Load MAR from the address bus |
| abus_to_pc | output | 1 | Load the PC from the address bus |
| mar_to_maddr | output | 1 | MAR drives the memory address bus |
| mdata_to_mbr | output | 1 | Load MBR from the memory data bus |
| mbr_to_mdata | output | 1 | MBR drives the memory data bus |
| mbr_to_mbus | output | 1 | MBR drives the internal memory-side bus |
| mbus_to_ir | output | 1 | Load IR from the memory-side bus |
| mbus_to_alub | output | 1 | Memory-side bus feeds ALU input B |
| alu_add | output | 1 | ALU computes A+B |
| alu_pass_b | output | 1 | ALU passes B (passes A when neither select is set) |
| rbus_to_ac | output | 1 | Load AC from the result bus |
| rbus_to_mbr | output | 1 | Load MBR from the result bus |
| mem_rd_nwr | output | 1 | Memory direction: 1 read, 0 write |
| mem_req | output | 1 | Memory request |

## Verification
The bench wraps the controller in a behavioural datapath and a memory with varying latency. It runs a program that goes through both outcomes of the branch. It also includes an add whose two negative operands wrap to a positive result, which a design that took the sign from the wrong place or skipped the branch would get wrong. A reset in the middle of execution checks the two-edge synchronizer latency, the PC clear and the dropped request. A design without a synchronizer would react one edge early, and one that forgot the request would leave memory hung. The bench then holds Wait low at the first fetch. A controller that ignored Wait in IF0 would raise Request too early. A monitor watches every Request edge against Wait, so a design that dropped Request before memory finished would be caught.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

    localparam int OPC_W   = 2;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_RES, ST_IF0, ST_IF1, ST_IF2, ST_OD,
        ST_LD0, ST_LD1, ST_LD2,
        ST_AD0, ST_AD1, ST_AD2,
        ST_ST0, ST_ST1, ST_BR0
    } state_e;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_ADD   = 2'b10,
        OP_BRNEG = 2'b11
    } opc_e;

    typedef struct packed {
        logic pc_clr;
        logic pc_inc;
        logic pc_to_abus;
        logic ir_to_abus;
        logic abus_to_mar;
        logic abus_to_pc;
        logic mar_to_maddr;
        logic mdata_to_mbr;
        logic mbr_to_mdata;
        logic mbr_to_mbus;
        logic mbus_to_ir;
        logic mbus_to_alub;
        logic alu_add;
        logic alu_pass_b;
        logic rbus_to_ac;
        logic rbus_to_mbr;
        logic mem_rd_nwr;
        logic mem_req;
    } uop_t;

    function automatic uop_t add_fetch_start(uop_t u);
        uop_t r = u;
        r.pc_to_abus  = 1'b1;
        r.abus_to_mar = 1'b1;
        r.pc_inc      = 1'b1;
        return r;
    endfunction

    function automatic uop_t add_read_wait(uop_t u, logic wait_hi);
        uop_t r = u;
        r.mar_to_maddr = 1'b1;
        r.mem_rd_nwr   = 1'b1;
        r.mem_req      = wait_hi;
        r.mdata_to_mbr = ~wait_hi;
        return r;
    endfunction

endpackage

// File: rtl/acc_sync_chain.sv
module acc_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_async,
    output logic q_sync
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) chain_q <= d_async;
        end else begin : g_multi
            always_ff @(posedge clk) chain_q <= {chain_q[TOP-1:0], d_async};
        end
    endgenerate

    assign q_sync = chain_q[TOP];
endmodule

// File: rtl/acc_ctrl_next.sv
module acc_ctrl_next
    import acc_ctrl_pkg::*;
(
    input  state_e           state,
    input  logic             rst_sync,
    input  logic             wait_sync,
    input  logic [OPC_W-1:0] opcode,
    output state_e           state_nx
);
    always_comb begin
        state_nx = state;
        if (rst_sync) begin
            state_nx = ST_RES;
        end else begin
            unique case (state)
                ST_RES: state_nx = ST_IF0;
                ST_IF0: state_nx = wait_sync ? ST_IF1 : ST_IF0;
                ST_IF1: state_nx = wait_sync ? ST_IF1 : ST_IF2;
                ST_IF2: state_nx = wait_sync ? ST_OD  : ST_IF2;
                ST_OD: begin
                    unique case (opc_e'(opcode))
                        OP_LOAD:  state_nx = ST_LD0;
                        OP_STORE: state_nx = ST_ST0;
                        OP_ADD:   state_nx = ST_AD0;
                        OP_BRNEG: state_nx = ST_BR0;
                    endcase
                end
                ST_LD0: state_nx = ST_LD1;
                ST_LD1: state_nx = wait_sync ? ST_LD1 : ST_LD2;
                ST_LD2: state_nx = ST_IF0;
                ST_AD0: state_nx = ST_AD1;
                ST_AD1: state_nx = wait_sync ? ST_AD1 : ST_AD2;
                ST_AD2: state_nx = ST_IF0;
                ST_ST0: state_nx = ST_ST1;
                ST_ST1: state_nx = wait_sync ? ST_ST1 : ST_IF0;
                ST_BR0: state_nx = ST_IF0;
                default: state_nx = ST_RES;
            endcase
        end
    end
endmodule

// File: rtl/acc_ctrl_uop.sv
module acc_ctrl_uop
    import acc_ctrl_pkg::*;
(
    input  state_e           state,
    input  logic             rst_sync,
    input  logic             wait_sync,
    input  logic [OPC_W-1:0] opcode,
    input  logic             acc_sign,
    output uop_t             uop
);
    always_comb begin
        uop            = '0;
        uop.mem_rd_nwr = 1'b1;
        if (rst_sync) begin
            uop.pc_clr = 1'b1;
        end else begin
            unique case (state)
                ST_RES: uop = add_fetch_start(uop);
                ST_IF0: begin
                    if (wait_sync) begin
                        uop.mar_to_maddr = 1'b1;
                        uop.mem_req      = 1'b1;
                    end
                end
                ST_IF1, ST_LD1, ST_AD1: uop = add_read_wait(uop, wait_sync);
                ST_IF2: begin
                    if (wait_sync) begin
                        uop.mbr_to_mbus = 1'b1;
                        uop.mbus_to_ir  = 1'b1;
                    end
                end
                ST_OD: begin
                    unique case (opc_e'(opcode))
                        OP_LOAD, OP_ADD: begin
                            uop.ir_to_abus  = 1'b1;
                            uop.abus_to_mar = 1'b1;
                        end
                        OP_STORE: begin
                            uop.ir_to_abus  = 1'b1;
                            uop.abus_to_mar = 1'b1;
                            uop.rbus_to_mbr = 1'b1;
                        end
                        OP_BRNEG: begin
                            uop.ir_to_abus = acc_sign;
                            uop.abus_to_pc = acc_sign;
                        end
                    endcase
                end
                ST_LD0, ST_AD0: begin
                    uop.mar_to_maddr = 1'b1;
                    uop.mem_req      = 1'b1;
                end
                ST_LD2, ST_AD2: begin
                    uop              = add_fetch_start(uop);
                    uop.mbr_to_mbus  = 1'b1;
                    uop.mbus_to_alub = 1'b1;
                    uop.rbus_to_ac   = 1'b1;
                    uop.alu_pass_b   = (state == ST_LD2);
                    uop.alu_add      = (state == ST_AD2);
                end
                ST_ST0, ST_ST1: begin
                    uop.mar_to_maddr = 1'b1;
                    uop.mbr_to_mdata = 1'b1;
                    uop.mem_rd_nwr   = 1'b0;
                    uop.mem_req      = (state == ST_ST0) || wait_sync;
                    if (state == ST_ST1 && !wait_sync) begin
                        uop = add_fetch_start(uop);
                    end
                end
                ST_BR0: uop = add_fetch_start(uop);
                default: uop.pc_clr = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
    import acc_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             ext_reset,
    input  logic             mem_wait,
    input  logic [OPC_W-1:0] ir_opcode,
    input  logic             acc_sign,
    output logic             pc_clr,
    output logic             pc_inc,
    output logic             pc_to_abus,
    output logic             ir_to_abus,
    output logic             abus_to_mar,
    output logic             abus_to_pc,
    output logic             mar_to_maddr,
    output logic             mdata_to_mbr,
    output logic             mbr_to_mdata,
    output logic             mbr_to_mbus,
    output logic             mbus_to_ir,
    output logic             mbus_to_alub,
    output logic             alu_add,
    output logic             alu_pass_b,
    output logic             rbus_to_ac,
    output logic             rbus_to_mbr,
    output logic             mem_rd_nwr,
    output logic             mem_req
);
    logic   rst_sync;
    logic   wait_sync;
    state_e state_q;
    state_e state_nx;
    uop_t   uop;

    acc_sync_chain #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(clk), .d_async(ext_reset), .q_sync(rst_sync)
    );
    acc_sync_chain #(.STAGES(SYNC_STAGES)) u_wait_sync (
        .clk(clk), .d_async(mem_wait), .q_sync(wait_sync)
    );

    acc_ctrl_next u_next (
        .state(state_q), .rst_sync(rst_sync), .wait_sync(wait_sync),
        .opcode(ir_opcode), .state_nx(state_nx)
    );

    acc_ctrl_uop u_uop (
        .state(state_q), .rst_sync(rst_sync), .wait_sync(wait_sync),
        .opcode(ir_opcode), .acc_sign(acc_sign), .uop(uop)
    );

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_nx;
    end

    assign pc_clr       = uop.pc_clr;
    assign pc_inc       = uop.pc_inc;
    assign pc_to_abus   = uop.pc_to_abus;
    assign ir_to_abus   = uop.ir_to_abus;
    assign abus_to_mar  = uop.abus_to_mar;
    assign abus_to_pc   = uop.abus_to_pc;
    assign mar_to_maddr = uop.mar_to_maddr;
    assign mdata_to_mbr = uop.mdata_to_mbr;
    assign mbr_to_mdata = uop.mbr_to_mdata;
    assign mbr_to_mbus  = uop.mbr_to_mbus;
    assign mbus_to_ir   = uop.mbus_to_ir;
    assign mbus_to_alub = uop.mbus_to_alub;
    assign alu_add      = uop.alu_add;
    assign alu_pass_b   = uop.alu_pass_b;
    assign rbus_to_ac   = uop.rbus_to_ac;
    assign rbus_to_mbr  = uop.rbus_to_mbr;
    assign mem_rd_nwr   = uop.mem_rd_nwr;
    assign mem_req      = uop.mem_req;

    // Checks guarding the state register and handshake
    logic rst_seen_q = 1'b0;
    always_ff @(posedge clk) begin
        rst_seen_q <= rst_sync;
        if (rst_seen_q) begin
            assert_reset_state_R1: assert (state_q == ST_RES)
                else $error("state not RES after synchronized reset");
        end
    end

    assert_abus_single_R2: assert property (@(posedge clk) disable iff (rst_sync)
        $onehot0({pc_to_abus, ir_to_abus}));

    assert_req_start_R3: assert property (@(posedge clk) disable iff (rst_sync)
        $rose(mem_req) |-> wait_sync);

    assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst_sync)
        $fell(mem_req) |-> !wait_sync);

    assert_write_dir_R8: assert property (@(posedge clk) disable iff (rst_sync)
        mbr_to_mdata |-> !mem_rd_nwr);

    assert_branch_refetch_R9: assert property (@(posedge clk) disable iff (rst_sync)
        abus_to_pc |=> (pc_to_abus && abus_to_mar && pc_inc));
endmodule

// File: tb/acc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module acc_seq_ctrl_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic ext_reset = 1'b1;
    logic hold_wait = 1'b0;
    logic mwait = 1'b1;
    logic mem_wait;
    logic [1:0] ir_opcode;
    logic acc_sign;
    logic pc_clr, pc_inc, pc_to_abus, ir_to_abus, abus_to_mar, abus_to_pc;
    logic mar_to_maddr, mdata_to_mbr, mbr_to_mdata, mbr_to_mbus, mbus_to_ir;
    logic mbus_to_alub, alu_add, alu_pass_b, rbus_to_ac, rbus_to_mbr;
    logic mem_rd_nwr, mem_req;

    assign mem_wait = hold_wait ? 1'b0 : mwait;

    acc_seq_ctrl dut_i (
        .clk(clk), .ext_reset(ext_reset), .mem_wait(mem_wait),
        .ir_opcode(ir_opcode), .acc_sign(acc_sign),
        .pc_clr(pc_clr), .pc_inc(pc_inc), .pc_to_abus(pc_to_abus),
        .ir_to_abus(ir_to_abus), .abus_to_mar(abus_to_mar), .abus_to_pc(abus_to_pc),
        .mar_to_maddr(mar_to_maddr), .mdata_to_mbr(mdata_to_mbr),
        .mbr_to_mdata(mbr_to_mdata), .mbr_to_mbus(mbr_to_mbus),
        .mbus_to_ir(mbus_to_ir), .mbus_to_alub(mbus_to_alub), .alu_add(alu_add),
        .alu_pass_b(alu_pass_b), .rbus_to_ac(rbus_to_ac), .rbus_to_mbr(rbus_to_mbr),
        .mem_rd_nwr(mem_rd_nwr), .mem_req(mem_req)
    );

    // Behavioural datapath
    logic [13:0] pc = '0, mar = '0;
    logic [15:0] mbr = '0, ir = '0, ac = '0, rdata = '0;
    logic [13:0] abus;
    logic [15:0] alu_b, alu_y;
    assign abus  = pc_to_abus ? pc : (ir_to_abus ? ir[13:0] : 14'h0);
    assign alu_b = mbus_to_alub ? mbr : 16'h0;
    assign alu_y = alu_add ? (ac + alu_b) : (alu_pass_b ? alu_b : ac);
    assign ir_opcode = ir[15:14];
    assign acc_sign  = ac[15];

    logic [15:0] mem [0:63];
    int fetch_cnt = 0;
    int mstate = 0, mcnt = 0, txn = 0;
    logic [5:0] maddr = '0;
    logic mwr = 1'b0;
    logic req_prev = 1'b0;
    logic mon_en = 1'b0;
    int proto_bad = 0;

    always @(posedge clk) begin
        if (pc_clr) pc <= '0;
        else if (abus_to_pc) pc <= abus;
        else if (pc_inc) pc <= pc + 14'd1;
        if (abus_to_mar) mar <= abus;
        if (mdata_to_mbr) mbr <= rdata;
        else if (rbus_to_mbr) mbr <= alu_y;
        if (mbus_to_ir) ir <= mbr;
        if (rbus_to_ac) ac <= alu_y;

        if (ext_reset) fetch_cnt <= 0;
        else if (pc_to_abus && abus_to_mar) fetch_cnt <= fetch_cnt + 1;

        // Memory responder, four-phase handshake
        if (ext_reset) begin
            mstate <= 0;
            mwait  <= 1'b1;
        end else begin
            case (mstate)
                0: if (mem_req && mar_to_maddr) begin
                    maddr  <= mar[5:0];
                    mwr    <= ~mem_rd_nwr;
                    mcnt   <= 1 + (txn % 3);
                    txn    <= txn + 1;
                    mstate <= 1;
                end
                1: if (mcnt <= 1) begin
                    if (mwr) mem[maddr] <= mbr;
                    else     rdata <= mem[maddr];
                    mwait  <= 1'b0;
                    mstate <= 2;
                end else mcnt <= mcnt - 1;
                default: if (!mem_req) begin
                    mwait  <= 1'b1;
                    mstate <= 0;
                end
            endcase
        end

        // R10 protocol monitor
        req_prev <= mem_req;
        if (mon_en && !ext_reset) begin
            if (req_prev && !mem_req && mem_wait) proto_bad <= proto_bad + 1;
            if (!req_prev && mem_req && !mem_wait) proto_bad <= proto_bad + 1;
        end
    end

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {instruction, AC after it, MAR at next fetch}
    localparam logic [47:0] EXEC_VEC [0:13] = '{
        {16'h0028, 16'h0005, 16'd1},
        {16'h802A, 16'h0008, 16'd2},
        {16'hC00A, 16'h0008, 16'd3},
        {16'h4032, 16'h0008, 16'd4},
        {16'h0029, 16'h7FFE, 16'd5},
        {16'h802A, 16'h8001, 16'd6},
        {16'hC009, 16'h8001, 16'd9},
        {16'h4033, 16'h8001, 16'd10},
        {16'h802B, 16'h0001, 16'd11},
        {16'hC000, 16'h0001, 16'd12},
        {16'h4034, 16'h0001, 16'd13},
        {16'h002B, 16'h8000, 16'd14},
        {16'hC00E, 16'h8000, 16'd14},
        {16'hC00E, 16'h8000, 16'd14}
    };

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
        mem[0]  = 16'h0028; mem[1]  = 16'h802A; mem[2]  = 16'hC00A;
        mem[3]  = 16'h4032; mem[4]  = 16'h0029; mem[5]  = 16'h802A;
        mem[6]  = 16'hC009; mem[7]  = 16'h0028; mem[8]  = 16'h0028;
        mem[9]  = 16'h4033; mem[10] = 16'h802B; mem[11] = 16'hC000;
        mem[12] = 16'h4034; mem[13] = 16'h002B; mem[14] = 16'hC00E;
        mem[40] = 16'h0005; mem[41] = 16'h7FFE; mem[42] = 16'h0003;
        mem[43] = 16'h8000;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int quiet_req;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pc_clr", {31'd0, pc_clr}, 32'd1);
        chk("R1 reset req", {31'd0, mem_req}, 32'd0);
        ext_reset = 1'b0;
        mon_en    = 1'b1;

        // Program walk
        for (int k = 0; k < 14; k++) begin
            logic [15:0] ins, e_ac, e_mar;
            string tg;
            {ins, e_ac, e_mar} = EXEC_VEC[k];
            wait (fetch_cnt == k + 2);
            @(negedge clk);
            chk("R4 R5 IR", {16'd0, ir}, {16'd0, ins});
            case (ins[15:14])
                2'b00: tg = "R6 R7 load AC";
                2'b01: tg = "R8 store AC";
                2'b10: tg = "R7 add AC";
                default: tg = "R9 branch AC";
            endcase
            chk(tg, {16'd0, ac}, {16'd0, e_ac});
            chk(ins[15:14] == 2'b11 ? "R9 next MAR" : "R2 next MAR",
                {18'd0, mar}, {16'd0, e_mar});
            if (ins[15:14] == 2'b01)
                chk("R8 stored word", {16'd0, mem[ins[5:0]]}, {16'd0, e_ac});
        end

        // Reset mid-run: two-edge latency, PC clear, request low
        @(negedge clk);
        ext_reset = 1'b1;
        hold_wait = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 sync latency pc_clr early", {31'd0, pc_clr}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R1 pc_clr after two edges", {31'd0, pc_clr}, 32'd1);
        chk("R1 req low in reset", {31'd0, mem_req}, 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 PC cleared", {18'd0, pc}, 32'd0);
        ext_reset = 1'b0;

        // Fetch stalls while Wait is held low
        wait (fetch_cnt == 1);
        @(negedge clk);
        chk("R2 MAR from old PC", {18'd0, mar}, 32'd0);
        chk("R2 PC incremented", {18'd0, pc}, 32'd1);
        quiet_req = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (mem_req) quiet_req++;
        end
        chk("R3 no request while Wait low", quiet_req, 32'd0);
        hold_wait = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R3 req one edge after Wait", {31'd0, mem_req}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R3 req two edges after Wait", {31'd0, mem_req}, 32'd1);
        chk("R3 read direction", {31'd0, mem_rd_nwr}, 32'd1);

        wait (fetch_cnt == 2);
        @(negedge clk);
        chk("R7 rerun load AC", {16'd0, ac}, 32'h0005);
        chk("R2 rerun MAR", {18'd0, mar}, 32'd1);
        chk("R10 handshake order", proto_bad, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule